// File: doc/BRIEF.md
# Fuse Program Permission Checker

This block sits between a program-address write and a one-time-programmable fuse array. Each accepted request carries one 17-bit address. The block splits that address into page, row and column. It then decides whether the addressed fuse may be programmed, using four inputs to the decision:

- a global program enable;
- a sticky lock that covers a span of page-0 rows;
- a fixed table that ties protected page-0 rows to lock fuses;
- a guarded range on page 2 that one page-0 lock fuse controls.

Lock fuses sit in the same array that is being programmed, so the decision needs a read of the array before the write can happen. If the request is allowed, the addressed bit is set. Bits are only ever set. Every attempt raises a sticky done flag, and a refused or impossible attempt also raises a sticky error flag. Software clears both flags with write-one-to-clear strobes.

A four-state controller sequences the work. The states are ST_IDLE, ST_DECODE, ST_LOOKUP and ST_COMMIT.

- ST_IDLE goes to ST_DECODE on an accepted request (`req_valid` while `req_ready`). At that edge the address, the enable and the sticky-lock state are captured.
- ST_DECODE goes to ST_LOOKUP unconditionally. At that edge the decoded fields and the lock-fuse coordinates are registered.
- ST_LOOKUP goes to ST_COMMIT unconditionally. At that edge the lock-fuse row is read and the final verdict is registered.
- ST_COMMIT goes to ST_IDLE unconditionally. At that edge the fuse is set, if permitted, and the flags are raised.

A read port lets the surrounding logic inspect any row of the array.

Top module: `efp_prog_guard`

## Requirements
- R1: The request address holds the column in bits 4:0, the row in bits 12:5 and the page in bits 16:13. A permitted request sets exactly the addressed bit, and that bit then reads back through the row read port.
- R2: When `prog_en` is 0 at acceptance, the request is refused: `err_flag` is set and the array is unchanged.
- R3: A pulse on `range_lock_set` makes `range_locked` 1 until reset. While it is set at acceptance, page-0 requests from row 44 column 0 through row 51 column 31 are refused. Reset returns `range_locked` to 0.
- R4: Page-0 rows are refused when their lock fuse reads 1. The lock fuse for each row group is:

  | Page-0 rows | Lock fuse (page 0) |
  |---|---|
  | 4 | row 4 column 31 |
  | 8–11 | row 43 column 27 |
  | 12–19 | row 43 column 11 |
  | 20–27 | row 43 column 13 |
  | 28–35 | row 43 column 15 |
  | 37 | row 43 column 28 |
  | 64–71 | row 43 column 6 |
  | 72–79 | row 43 column 7 |
  | 80–87 | row 43 column 8 |

- R5: Page-2 requests from row 129 column 0 through row 255 column 27 are refused when page-0 row 43 column 16 reads 1. All other page-2 addresses are never row-locked.
- R6: Page-0 rows without a table entry, and page 1, are never row-locked. With `prog_en` at 1 and the sticky lock not covering them, they are programmed.
- R7: Every attempt sets `done_flag`. Refused or impossible attempts also set `err_flag`. The hardware never clears either flag; only `done_clr` / `err_clr` or reset clear them.
- R8: Programming only sets bits. Programming a bit that is already 1 counts as success and leaves the row unchanged.
- R9: A page at or above the array's page count (3) cannot be programmed. It raises `err_flag`, and the read port returns 0 for such a page.
- R10: Results appear 3 clock edges after the accepting edge. `req_ready` is 0 from the accepting edge until the commit edge, and requests offered while it is 0 are ignored.
- R11: Reset clears the fuse array, both flags and the sticky lock, and sets `req_ready` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request strobe |
| req_addr | input | 17 | Program address: page, row, column |
| req_ready | output | 1 | Controller idle; a request is accepted |
| prog_en | input | 1 | Global program enable |
| range_lock_set | input | 1 | Sets the sticky page-0 span lock |
| range_locked | output | 1 | Sticky span lock state |
| done_flag | output | 1 | Sticky attempt-finished flag |
| err_flag | output | 1 | Sticky attempt-refused flag |
| done_clr | input | 1 | Clears `done_flag` |
| err_clr | input | 1 | Clears `err_flag` |
| rd_page | input | 4 | Read-port page |
| rd_row | input | 8 | Read-port row |
| rd_data | output | 32 | Contents of the selected row |

## Verification
Done, error and the fuse write all land on the third rising edge after the accepting edge. The error flag therefore rises together with the done flag, and the array row changes on that same edge. The bench records the cycle of acceptance. Its monitor treats the first falling edge at which `done_flag` is high as the result point. There it checks the elapsed count is exactly 3, compares the error flag and reads the row back through the read port. Ignored requests are judged only after the busy window has closed, by reading back the row they would have touched.

// File: rtl/efp_pkg.sv
package efp_pkg;

    localparam int PAGE_W   = 4;
    localparam int ROW_W    = 8;
    localparam int COL_W    = 5;
    localparam int ADDR_W   = PAGE_W + ROW_W + COL_W;
    localparam int COLS     = 1 << COL_W;
    localparam int ROWS     = 1 << ROW_W;
    localparam int COL_LSB  = 0;
    localparam int ROW_LSB  = COL_W;
    localparam int PAGE_LSB = COL_W + ROW_W;

    // page-0 row that carries most lock fuses
    localparam logic [ROW_W-1:0] CTRL_ROW      = 8'd43;
    // span covered by the sticky lock (page 0)
    localparam logic [ROW_W-1:0] SPAN_LO       = 8'd44;
    localparam logic [ROW_W-1:0] SPAN_HI       = 8'd51;
    // guarded range on page 2
    localparam logic [PAGE_W-1:0] GUARD_PAGE   = 4'd2;
    localparam logic [ROW_W-1:0] GUARD_ROW_LO  = 8'd129;
    localparam logic [ROW_W-1:0] GUARD_ROW_HI  = 8'd255;
    localparam logic [COL_W-1:0] GUARD_COL_END = 5'd27;
    localparam logic [COL_W-1:0] GUARD_LK_COL  = 5'd16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_LOOKUP,
        ST_COMMIT
    } efp_state_e;

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } lock_ref_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              hard_deny;
        logic              no_cell;
        lock_ref_t         lock;
    } efp_dec_t;

    // Fixed page-0 protection table: protected row -> lock fuse (page 0).
    function automatic lock_ref_t page0_lock_of(input logic [ROW_W-1:0] row);
        lock_ref_t r;
        r.valid = 1'b1;
        r.row   = CTRL_ROW;
        r.col   = '0;
        if (row == 8'd4) begin
            r.row = 8'd4;
            r.col = 5'd31;
        end else if (row >= 8'd8 && row <= 8'd11) begin
            r.col = 5'd27;
        end else if (row >= 8'd12 && row <= 8'd19) begin
            r.col = 5'd11;
        end else if (row >= 8'd20 && row <= 8'd27) begin
            r.col = 5'd13;
        end else if (row >= 8'd28 && row <= 8'd35) begin
            r.col = 5'd15;
        end else if (row == 8'd37) begin
            r.col = 5'd28;
        end else if (row >= 8'd64 && row <= 8'd71) begin
            r.col = 5'd6;
        end else if (row >= 8'd72 && row <= 8'd79) begin
            r.col = 5'd7;
        end else if (row >= 8'd80 && row <= 8'd87) begin
            r.col = 5'd8;
        end else begin
            r.valid = 1'b0;
            r.row   = '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/efp_decode.sv
module efp_decode
    import efp_pkg::*;
#(
    parameter int NUM_PAGES = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic              span_lock,
    output efp_dec_t          dec
);

    logic [PAGE_W-1:0] page;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic              on_page0;
    logic              in_span;
    logic              in_guard;
    lock_ref_t         lock;

    always_comb begin
        page     = addr[PAGE_LSB +: PAGE_W];
        row      = addr[ROW_LSB +: ROW_W];
        col      = addr[COL_LSB +: COL_W];
        on_page0 = (page == '0);
        in_span  = on_page0 && (row >= SPAN_LO) && (row <= SPAN_HI);
        in_guard = (page == GUARD_PAGE) && (row >= GUARD_ROW_LO) &&
                   !((row == GUARD_ROW_HI) && (col > GUARD_COL_END));

        if (on_page0) begin
            lock = page0_lock_of(row);
        end else if (in_guard) begin
            lock.valid = 1'b1;
            lock.row   = CTRL_ROW;
            lock.col   = GUARD_LK_COL;
        end else begin
            lock = '0;
        end

        dec.page      = page;
        dec.row       = row;
        dec.col       = col;
        dec.hard_deny = !en || (span_lock && in_span);
        dec.no_cell   = (page >= PAGE_W'(NUM_PAGES));
        dec.lock      = lock;
    end

endmodule

// File: rtl/efp_fuse_array.sv
module efp_fuse_array
    import efp_pkg::*;
#(
    parameter int NUM_PAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [PAGE_W-1:0] set_page,
    input  logic [ROW_W-1:0]  set_row,
    input  logic [COL_W-1:0]  set_col,
    input  logic [ROW_W-1:0]  lk_row,
    output logic [COLS-1:0]   lk_data,
    input  logic [PAGE_W-1:0] ext_page,
    input  logic [ROW_W-1:0]  ext_row,
    output logic [COLS-1:0]   ext_data
);

    localparam int WORDS = NUM_PAGES * ROWS;

    logic [COLS-1:0] words [WORDS];

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic [COLS-1:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (set_en && (set_page == PAGE_W'(p)) &&
                             (set_row == ROW_W'(r))) begin
                    word_q[set_col] <= 1'b1;
                end
            end
            assign words[p*ROWS + r] = word_q;
        end
    end

    // lock fuses all live on page 0
    assign lk_data = words[int'(lk_row)];

    always_comb begin
        ext_data = '0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (ext_page == PAGE_W'(p)) begin
                ext_data = words[p*ROWS + int'(ext_row)];
            end
        end
    end

endmodule

// File: rtl/efp_ctrl.sv
module efp_ctrl
    import efp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              prog_en,
    input  logic              span_lock,
    output logic              req_ready,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_en,
    output logic              cap_lock,
    input  efp_dec_t          dec,
    output logic [ROW_W-1:0]  lk_row,
    input  logic [COLS-1:0]   lk_data,
    output logic              set_en,
    output logic [PAGE_W-1:0] set_page,
    output logic [ROW_W-1:0]  set_row,
    output logic [COL_W-1:0]  set_col,
    output logic              done_set,
    output logic              err_set
);

    efp_state_e state_q, state_d;
    efp_dec_t   dec_q;
    logic       deny_q;
    logic       accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_en   <= 1'b0;
            cap_lock <= 1'b0;
            dec_q    <= '0;
            deny_q   <= 1'b0;
        end else begin
            if (accept) begin
                cap_addr <= req_addr;
                cap_en   <= prog_en;
                cap_lock <= span_lock;
            end
            if (state_q == ST_DECODE) begin
                dec_q <= dec;
            end
            if (state_q == ST_LOOKUP) begin
                deny_q <= dec_q.hard_deny || dec_q.no_cell ||
                          (dec_q.lock.valid && lk_data[dec_q.lock.col]);
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        set_en    = 1'b0;
        done_set  = 1'b0;
        err_set   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    state_d = ST_DECODE;
                end
            end
            ST_DECODE: begin
                state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                set_en   = !deny_q;
                done_set = 1'b1;
                err_set  = deny_q;
                state_d  = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign lk_row   = dec_q.lock.row;
    assign set_page = dec_q.page;
    assign set_row  = dec_q.row;
    assign set_col  = dec_q.col;

endmodule

// File: rtl/efp_prog_guard.sv
module efp_prog_guard
    import efp_pkg::*;
#(
    parameter int NUM_PAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              prog_en,
    input  logic              range_lock_set,
    output logic              range_locked,
    output logic              done_flag,
    output logic              err_flag,
    input  logic              done_clr,
    input  logic              err_clr,
    input  logic [PAGE_W-1:0] rd_page,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [COLS-1:0]   rd_data
);

    logic [ADDR_W-1:0] cap_addr;
    logic              cap_en;
    logic              cap_lock;
    efp_dec_t          dec;
    logic [ROW_W-1:0]  lk_row;
    logic [COLS-1:0]   lk_data;
    logic              set_en;
    logic [PAGE_W-1:0] set_page;
    logic [ROW_W-1:0]  set_row;
    logic [COL_W-1:0]  set_col;
    logic              done_set;
    logic              err_set;

    // sticky span lock: only reset clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            range_locked <= 1'b0;
        end else if (range_lock_set) begin
            range_locked <= 1'b1;
        end
    end

    // sticky result flags: a set wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (done_set) begin
                done_flag <= 1'b1;
            end else if (done_clr) begin
                done_flag <= 1'b0;
            end
            if (err_set) begin
                err_flag <= 1'b1;
            end else if (err_clr) begin
                err_flag <= 1'b0;
            end
        end
    end

    efp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .prog_en   (prog_en),
        .span_lock (range_locked),
        .req_ready (req_ready),
        .cap_addr  (cap_addr),
        .cap_en    (cap_en),
        .cap_lock  (cap_lock),
        .dec       (dec),
        .lk_row    (lk_row),
        .lk_data   (lk_data),
        .set_en    (set_en),
        .set_page  (set_page),
        .set_row   (set_row),
        .set_col   (set_col),
        .done_set  (done_set),
        .err_set   (err_set)
    );

    efp_decode #(.NUM_PAGES(NUM_PAGES)) u_dec (
        .addr      (cap_addr),
        .en        (cap_en),
        .span_lock (cap_lock),
        .dec       (dec)
    );

    efp_fuse_array #(.NUM_PAGES(NUM_PAGES)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_page (set_page),
        .set_row  (set_row),
        .set_col  (set_col),
        .lk_row   (lk_row),
        .lk_data  (lk_data),
        .ext_page (rd_page),
        .ext_row  (rd_row),
        .ext_data (rd_data)
    );

endmodule

// File: rtl/efp_prog_guard_chk.sv
module efp_prog_guard_chk
    import efp_pkg::*;
#(
    parameter int NUM_PAGES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              prog_en,
    input logic              range_locked,
    input logic              done_flag,
    input logic              err_flag,
    input logic              done_clr,
    input logic              err_clr,
    input logic              set_en,
    input logic [PAGE_W-1:0] set_page
);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !done_clr) |=> done_flag);

    // R7
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> done_flag);

    // R3
    span_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_locked |=> range_locked);

    // R2
    disabled_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !prog_en) |=> ##3 err_flag);

    // R9
    write_in_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> (set_page < PAGE_W'(NUM_PAGES)));

endmodule

bind efp_prog_guard efp_prog_guard_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .prog_en      (prog_en),
    .range_locked (range_locked),
    .done_flag    (done_flag),
    .err_flag     (err_flag),
    .done_clr     (done_clr),
    .err_clr      (err_clr),
    .set_en       (set_en),
    .set_page     (set_page)
);

// File: tb/efp_prog_guard_tb.sv
`timescale 1ns/1ps
module efp_prog_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [16:0] req_addr = '0;
    logic        req_ready;
    logic        prog_en = 1'b0;
    logic        range_lock_set = 1'b0;
    logic        range_locked;
    logic        done_flag;
    logic        err_flag;
    logic        done_clr = 1'b0;
    logic        err_clr = 1'b0;
    logic [3:0]  rd_page = '0;
    logic [7:0]  rd_row = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int          page;
        int          row;
        int          col;
        bit          err;
        logic [31:0] rowval;
        int          acc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [31:0] ref_mem [3][256];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    efp_prog_guard u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_ready      (req_ready),
        .prog_en        (prog_en),
        .range_lock_set (range_lock_set),
        .range_locked   (range_locked),
        .done_flag      (done_flag),
        .err_flag       (err_flag),
        .done_clr       (done_clr),
        .err_clr        (err_clr),
        .rd_page        (rd_page),
        .rd_row         (rd_row),
        .rd_data        (rd_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic clear_ref();
        for (int p = 0; p < 3; p++)
            for (int r = 0; r < 256; r++)
                ref_mem[p][r] = '0;
    endtask

    // reference verdict from the requirements
    function automatic bit model_err(input int page, input int row, input int col,
                                     input bit en, input bit lk);
        int lr;
        int lc;
        if (!en) return 1'b1;
        if (page >= 3) return 1'b1;
        if (page == 0) begin
            if (lk && row >= 44 && row <= 51) return 1'b1;
            lr = 43;
            lc = -1;
            case (row) inside
                4:        begin lr = 4; lc = 31; end
                [8:11]:   lc = 27;
                [12:19]:  lc = 11;
                [20:27]:  lc = 13;
                [28:35]:  lc = 15;
                37:       lc = 28;
                [64:71]:  lc = 6;
                [72:79]:  lc = 7;
                [80:87]:  lc = 8;
                default:  lc = -1;
            endcase
            if (lc >= 0) return ref_mem[0][lr][lc];
            return 1'b0;
        end
        if (page == 2 && row >= 129 && !(row == 255 && col > 27))
            return ref_mem[0][43][16];
        return 1'b0;
    endfunction

    task automatic wait_idle();
        while (exp_q.size() != 0 || done_flag || !req_ready) @(negedge clk);
    endtask

    // driver: one request, expected result pushed to the scoreboard
    task automatic do_prog(input int page, input int row, input int col,
                           input bit en, input string tag);
        exp_t e;
        wait_idle();
        e.page = page; e.row = row; e.col = col; e.tag = tag;
        e.err = model_err(page, row, col, en, range_locked);
        if (!e.err) ref_mem[page][row][col] = 1'b1;
        e.rowval = (page < 3) ? ref_mem[page][row] : 32'h0;
        prog_en   = en;
        req_addr  = {4'(page), 8'(row), 5'(col)};
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        e.acc = cyc;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pops and compares at the result point
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_flag) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 32'(done_flag), 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(err_flag == e.err, {e.tag, " err"}, 32'(err_flag), 32'(e.err));
                    // R10 latency from the accepting edge
                    check((cyc - e.acc) == 3, "R10 latency", 32'(cyc - e.acc), 32'd3);
                    rd_page = 4'(e.page);
                    rd_row  = 8'(e.row);
                    #1;
                    check(rd_data == e.rowval, {e.tag, " row"}, rd_data, e.rowval);
                end
                done_clr = 1'b1;
                err_clr  = 1'b1;
                @(negedge clk);
                done_clr = 1'b0;
                err_clr  = 1'b0;
            end
        end
    end

    task automatic peek(input int page, input int row, input logic [31:0] expv,
                        input string tag);
        wait_idle();
        rd_page = 4'(page);
        rd_row  = 8'(row);
        #1;
        check(rd_data == expv, tag, rd_data, expv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_ref();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(done_flag == 1'b0, "R11 done reset", 32'(done_flag), 32'h0);
        check(err_flag == 1'b0, "R11 err reset", 32'(err_flag), 32'h0);
        check(req_ready == 1'b1, "R11 ready reset", 32'(req_ready), 32'h1);
        check(range_locked == 1'b0, "R11 lock reset", 32'(range_locked), 32'h0);
        peek(0, 43, 32'h0, "R11 array blank");

        // R2 disabled
        do_prog(1, 5, 3, 1'b0, "R2 disabled");
        do_prog(0, 100, 0, 1'b0, "R2 disabled p0");
        // R1, R6 basic programming
        do_prog(1, 5, 3, 1'b1, "R1 p1r5c3");
        do_prog(1, 200, 31, 1'b1, "R1 p1r200c31");
        do_prog(0, 100, 31, 1'b1, "R6 unlisted row");
        do_prog(0, 43, 0, 1'b1, "R6 control row");
        // R8 already set
        do_prog(1, 5, 3, 1'b1, "R8 reprogram");
        // R4 table
        do_prog(0, 12, 0, 1'b1, "R4 before lock");
        do_prog(0, 43, 11, 1'b1, "R4 set lock 11");
        do_prog(0, 19, 5, 1'b1, "R4 row19 locked");
        do_prog(0, 20, 0, 1'b1, "R4 row20 other lock");
        do_prog(0, 4, 0, 1'b1, "R4 row4 open");
        do_prog(0, 4, 31, 1'b1, "R4 row4 self lock");
        do_prog(0, 4, 2, 1'b1, "R4 row4 locked");
        do_prog(0, 43, 6, 1'b1, "R4 set lock 6");
        do_prog(0, 71, 0, 1'b1, "R4 row71 locked");
        do_prog(0, 72, 0, 1'b1, "R4 row72 open");
        do_prog(0, 43, 28, 1'b1, "R4 set lock 28");
        do_prog(0, 37, 9, 1'b1, "R4 row37 locked");
        do_prog(0, 88, 9, 1'b1, "R6 row88 open");
        // R5 page-2 guard
        do_prog(2, 129, 0, 1'b1, "R5 guard open");
        do_prog(0, 43, 16, 1'b1, "R5 set lock 16");
        do_prog(2, 129, 0, 1'b1, "R5 guard set bit");
        do_prog(2, 200, 7, 1'b1, "R5 guard mid");
        do_prog(2, 255, 27, 1'b1, "R5 guard end");
        do_prog(2, 255, 28, 1'b1, "R5 past end");
        do_prog(2, 128, 5, 1'b1, "R5 below range");
        // R3 sticky span lock
        do_prog(0, 44, 0, 1'b1, "R3 before lock");
        wait_idle();
        range_lock_set = 1'b1;
        @(negedge clk);
        range_lock_set = 1'b0;
        repeat (3) @(negedge clk);
        check(range_locked == 1'b1, "R3 lock sticky", 32'(range_locked), 32'h1);
        do_prog(0, 44, 1, 1'b1, "R3 span start");
        do_prog(0, 51, 31, 1'b1, "R3 span end");
        do_prog(0, 52, 0, 1'b1, "R3 after span");
        do_prog(1, 45, 0, 1'b1, "R3 other page");
        // R9 missing pages
        do_prog(3, 1, 1, 1'b1, "R9 page3");
        do_prog(15, 255, 31, 1'b1, "R9 page15");
        peek(3, 1, 32'h0, "R9 read page3");

        // R10 requests during busy are ignored
        wait_idle();
        begin
            exp_t e;
            e.page = 1; e.row = 9; e.col = 9; e.tag = "R10 first";
            e.err = 1'b0;
            ref_mem[1][9][9] = 1'b1;
            e.rowval = ref_mem[1][9];
            prog_en   = 1'b1;
            req_addr  = {4'd1, 8'd9, 5'd9};
            req_valid = 1'b1;
            @(posedge clk);
            #1;
            e.acc = cyc;
            exp_q.push_back(e);
            @(negedge clk);
            req_addr = {4'd1, 8'd10, 5'd10};
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        peek(1, 10, 32'h0, "R10 busy ignored");

        // R3 / R11 reset clears lock and array
        wait_idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_ref();
        @(negedge clk);
        check(range_locked == 1'b0, "R3 reset clears lock", 32'(range_locked), 32'h0);
        peek(1, 5, 32'h0, "R11 array cleared");
        do_prog(0, 44, 5, 1'b1, "R3 span open after reset");

        wait_idle();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule